// File: doc/BRIEF.md
# Converter Command Byte Decoder

This block sits behind a serial front end that delivers whole 8-bit command bytes, each qualified by a one-cycle valid strobe. It sorts each byte into a command type by counting leading zeros before the first one. It keeps the conversion, setup, averaging and reset control fields in registers and exposes them. It also produces the control pulses that a converter core and its neighbours act on: a conversion request, pulses for the GPIO and DAC-select commands, and an active-low end-of-conversion flag.

The setup register's clock-mode field decides how a conversion begins. In modes 2 and 3 a conversion command written over the bus starts it. In modes 0 and 1 a falling edge on the conversion-start input starts it. Mode 3 also forces the effective scan and averaging settings off and holds the end-of-conversion flag high. A reset command can restore every register to its power-up value. The power-up value of the DAC input register comes from a resolution-select input.

Top module: `adc_cmd_decoder`

## Requirements
- R1: A valid byte with bit 7 = 1 loads the channel field from bits 6:3, the scan field from bits 2:1 and the temperature bit from bit 0. The new values are visible on the outputs after the next clock edge.
- R2: A valid byte with bits 7:6 = 01 loads the clock mode from bits 5:4, the reference select from bits 3:2 and the differential select from bits 1:0.
- R3: A valid byte with bits 7:5 = 001 loads the averaging enable from bit 4, the averaging count from bits 3:2 and the scan repeat count from bits 1:0.
- R4: A valid byte with bits 7:4 = 0001 raises `dac_sel_o` for exactly one cycle after the next clock edge. No register changes, whatever the low nibble holds.
- R5: Byte 0x03 pulses `gpio_cfg_o`, 0x02 pulses `gpio_wr_o` and 0x01 pulses `gpio_rd_o`, each for one cycle. Byte 0x00 and the unused bytes 0x04 to 0x07 produce no pulse and change no register.
- R6: After a hard reset the conversion, averaging and reset fields are all zero. The setup register holds 0x28 in bits 5:0, which is clock mode 2, reference select 2 and differential select 0. `dac_default_o` is 0xFFF when `res_sel_i` is high and 0x000 when it is low.
- R7: A valid byte with bits 7:3 = 00001 and bit 2 = 1 returns every register to its R6 value on the next clock, sampling `res_sel_i` at that edge. With bit 2 = 0, the byte stores bit 1 into `slow_o` and bit 0 into `fbgon_o`.
- R8: When the clock mode is 2 or 3, a conversion byte raises `conv_req_o` for one cycle after the next clock edge. When the clock mode is 0 or 1, a conversion byte loads its fields but raises no request.
- R9: When the clock mode is 0 or 1, a falling edge of `cnvst_n_i` raises `conv_req_o` for one cycle after the next clock edge. When the clock mode is 2 or 3, such an edge raises no request.
- R10: While the clock mode is 3, `eff_scan_o` is 00 and `eff_avg_en_o` is 0. In any other mode they follow the stored scan field and averaging enable.
- R11: Outside mode 3, `eoc_n_o` goes low the cycle after `conv_done_i` is high. It goes high the cycle after a falling edge of `cs_n_i` or `cnvst_n_i`. If a falling edge and `conv_done_i` occur in the same cycle, the edge wins.
- R12: Whenever the clock mode is 3, `eoc_n_o` is high, even if `conv_done_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cmd_byte_i | input | 8 | Command byte from the serial front end |
| cmd_valid_i | input | 1 | One-cycle strobe qualifying cmd_byte_i |
| cs_n_i | input | 1 | Chip select, active low |
| cnvst_n_i | input | 1 | Conversion start, active low |
| conv_done_i | input | 1 | Converter reports the last requested operation finished |
| res_sel_i | input | 1 | Resolution select for the DAC power-up value |
| chan_o | output | 4 | Channel select |
| scan_o | output | 2 | Stored scan mode |
| temp_o | output | 1 | Temperature select |
| clk_mode_o | output | 2 | Clock mode |
| ref_sel_o | output | 2 | Reference select |
| diff_sel_o | output | 2 | Differential/unipolar select |
| avg_en_o | output | 1 | Stored averaging enable |
| avg_cnt_o | output | 2 | Averaging count |
| scan_rep_o | output | 2 | Scan repeat count |
| eff_scan_o | output | 2 | Scan mode after the mode-3 override |
| eff_avg_en_o | output | 1 | Averaging enable after the mode-3 override |
| slow_o | output | 1 | Reset register slow bit |
| fbgon_o | output | 1 | Reset register reference-on bit |
| dac_default_o | output | 12 | Power-up value of the DAC input register |
| conv_req_o | output | 1 | One-cycle conversion request |
| gpio_cfg_o | output | 1 | One-cycle GPIO configure pulse |
| gpio_wr_o | output | 1 | One-cycle GPIO write pulse |
| gpio_rd_o | output | 1 | One-cycle GPIO read pulse |
| dac_sel_o | output | 1 | One-cycle DAC-select pulse |
| eoc_n_o | output | 1 | End-of-conversion flag, active low |

## Verification
The bench targets the prefix boundaries, where a decoder that compares too few leading bits would let a DAC-select, reset or unused byte write the averaging or setup register. It checks that those bytes leave every field unchanged. It checks that the start policy follows the clock mode in both directions: a design that ignored the mode would issue requests on bus writes in modes 0/1, or on strobe edges in modes 2/3, and the scoreboard would report an unexpected event. It also covers the mode-3 overrides of the flag and the effective scan settings, the case where a strobe edge and conversion-done occur in the same cycle, and a soft reset that re-samples the resolution select. A wrong choice in any of these would leave a stale or inverted output level.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

   typedef enum logic [3:0] {
      KIND_NOP,
      KIND_GPIO_RD,
      KIND_GPIO_WR,
      KIND_GPIO_CFG,
      KIND_UNUSED,
      KIND_RESET,
      KIND_DAC_SEL,
      KIND_AVG,
      KIND_SETUP,
      KIND_CONV
   } cmd_kind_e;

   typedef struct packed {
      logic [3:0] chan;
      logic [1:0] scan;
      logic       temp;
   } conv_reg_t;

   typedef struct packed {
      logic [1:0] clk_mode;
      logic [1:0] ref_sel;
      logic [1:0] diff_sel;
   } setup_reg_t;

   typedef struct packed {
      logic       en;
      logic [1:0] cnt;
      logic [1:0] rep;
   } avg_reg_t;

   typedef struct packed {
      logic slow;
      logic fbgon;
   } rst_reg_t;

   localparam logic [1:0] MODE_EXT_CLK = 2'b11;

endpackage

// File: rtl/adc_cmd_classify.sv
module adc_cmd_classify
   import adc_cmd_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_i,
   output cmd_kind_e         kind_o
);

   localparam int TOP = BYTE_W - 1;

   if (BYTE_W != 8) begin : g_bad_width
      $error("adc_cmd_classify: BYTE_W must be 8");
   end

   always_comb begin
      if (byte_i[TOP])
         kind_o = KIND_CONV;
      else if (byte_i[TOP-1])
         kind_o = KIND_SETUP;
      else if (byte_i[TOP-2])
         kind_o = KIND_AVG;
      else if (byte_i[TOP-3])
         kind_o = KIND_DAC_SEL;
      else if (byte_i[TOP-4])
         kind_o = KIND_RESET;
      else if (byte_i[TOP-5])
         kind_o = KIND_UNUSED;
      else begin
         case (byte_i[1:0])
            2'b11:   kind_o = KIND_GPIO_CFG;
            2'b10:   kind_o = KIND_GPIO_WR;
            2'b01:   kind_o = KIND_GPIO_RD;
            default: kind_o = KIND_NOP;
         endcase
      end
   end

endmodule

// File: rtl/adc_cmd_regs.sv
module adc_cmd_regs
   import adc_cmd_pkg::*;
#(
   parameter int         BYTE_W      = 8,
   parameter int         DAC_W       = 12,
   parameter logic [5:0] SETUP_PWRUP = 6'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  cmd_kind_e         kind_i,
   input  logic              res_sel_i,
   output conv_reg_t         conv_o,
   output setup_reg_t        setup_o,
   output avg_reg_t          avg_o,
   output rst_reg_t          rst_o,
   output logic [DAC_W-1:0]  dac_default_o
);

   localparam logic [DAC_W-1:0] DAC_ONES  = {DAC_W{1'b1}};
   localparam logic [DAC_W-1:0] DAC_ZEROS = {DAC_W{1'b0}};
   localparam int               SOFT_BIT  = 2;

   if (DAC_W < 1 || DAC_W > 16) begin : g_bad_dac
      $error("adc_cmd_regs: DAC_W out of range");
   end

   conv_reg_t        conv_q;
   setup_reg_t       setup_q;
   avg_reg_t         avg_q;
   rst_reg_t         rst_q;
   logic [DAC_W-1:0] dac_def_q;

   wire soft_rst = valid_i && (kind_i == KIND_RESET) && byte_i[SOFT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q    <= '0;
         setup_q   <= setup_reg_t'(SETUP_PWRUP);
         avg_q     <= '0;
         rst_q     <= '0;
         dac_def_q <= res_sel_i ? DAC_ONES : DAC_ZEROS;
      end else if (soft_rst) begin
         conv_q    <= '0;
         setup_q   <= setup_reg_t'(SETUP_PWRUP);
         avg_q     <= '0;
         rst_q     <= '0;
         dac_def_q <= res_sel_i ? DAC_ONES : DAC_ZEROS;
      end else if (valid_i) begin
         case (kind_i)
            KIND_CONV:  conv_q  <= conv_reg_t'(byte_i[6:0]);
            KIND_SETUP: setup_q <= setup_reg_t'(byte_i[5:0]);
            KIND_AVG:   avg_q   <= avg_reg_t'(byte_i[4:0]);
            KIND_RESET: rst_q   <= rst_reg_t'(byte_i[1:0]);
            default:    ;
         endcase
      end
   end

   assign conv_o        = conv_q;
   assign setup_o       = setup_q;
   assign avg_o         = avg_q;
   assign rst_o         = rst_q;
   assign dac_default_o = dac_def_q;

endmodule

// File: rtl/adc_cmd_start_eoc.sv
module adc_cmd_start_eoc
   import adc_cmd_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       cnvst_n_i,
   input  logic       conv_done_i,
   input  logic       conv_cmd_i,
   input  logic [1:0] clk_mode_i,
   output logic       conv_req_o,
   output logic       eoc_n_o
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("adc_cmd_start_eoc: SYNC_STAGES must be 0..4");
   end

   logic cs_n_s, cnvst_n_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign cs_n_s    = cs_n_i;
      assign cnvst_n_s = cnvst_n_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] cs_pipe, cv_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_pipe <= '1;
            cv_pipe <= '1;
         end else begin
            cs_pipe <= {cs_pipe[SYNC_STAGES-1:0] , cs_n_i} >> 0;
            cv_pipe <= {cv_pipe[SYNC_STAGES-1:0] , cnvst_n_i} >> 0;
         end
      end
      assign cs_n_s    = cs_pipe[SYNC_STAGES-1];
      assign cnvst_n_s = cv_pipe[SYNC_STAGES-1];
   end

   logic cs_prev, cv_prev, req_q, eoc_q;

   wire mode_ext   = (clk_mode_i == MODE_EXT_CLK);
   wire bus_start  = clk_mode_i[1];
   wire cs_fall    = cs_prev && !cs_n_s;
   wire cv_fall    = cv_prev && !cnvst_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev <= 1'b1;
         cv_prev <= 1'b1;
         req_q   <= 1'b0;
         eoc_q   <= 1'b1;
      end else begin
         cs_prev <= cs_n_s;
         cv_prev <= cnvst_n_s;
         req_q   <= bus_start ? conv_cmd_i : cv_fall;
         if (mode_ext || cs_fall || cv_fall)
            eoc_q <= 1'b1;
         else if (conv_done_i)
            eoc_q <= 1'b0;
      end
   end

   assign conv_req_o = req_q;
   assign eoc_n_o    = eoc_q || mode_ext;

endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
   import adc_cmd_pkg::*;
#(
   parameter int         BYTE_W      = 8,
   parameter int         DAC_W       = 12,
   parameter int         SYNC_STAGES = 0,
   parameter logic [5:0] SETUP_PWRUP = 6'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cmd_byte_i,
   input  logic              cmd_valid_i,
   input  logic              cs_n_i,
   input  logic              cnvst_n_i,
   input  logic              conv_done_i,
   input  logic              res_sel_i,
   output logic [3:0]        chan_o,
   output logic [1:0]        scan_o,
   output logic              temp_o,
   output logic [1:0]        clk_mode_o,
   output logic [1:0]        ref_sel_o,
   output logic [1:0]        diff_sel_o,
   output logic              avg_en_o,
   output logic [1:0]        avg_cnt_o,
   output logic [1:0]        scan_rep_o,
   output logic [1:0]        eff_scan_o,
   output logic              eff_avg_en_o,
   output logic              slow_o,
   output logic              fbgon_o,
   output logic [DAC_W-1:0]  dac_default_o,
   output logic              conv_req_o,
   output logic              gpio_cfg_o,
   output logic              gpio_wr_o,
   output logic              gpio_rd_o,
   output logic              dac_sel_o,
   output logic              eoc_n_o
);

   localparam int NPULSE = 4;

   cmd_kind_e  kind;
   conv_reg_t  conv_r;
   setup_reg_t setup_r;
   avg_reg_t   avg_r;
   rst_reg_t   rst_r;

   adc_cmd_classify #(.BYTE_W(BYTE_W)) u_classify (
      .byte_i (cmd_byte_i),
      .kind_o (kind)
   );

   adc_cmd_regs #(
      .BYTE_W      (BYTE_W),
      .DAC_W       (DAC_W),
      .SETUP_PWRUP (SETUP_PWRUP)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .valid_i       (cmd_valid_i),
      .byte_i        (cmd_byte_i),
      .kind_i        (kind),
      .res_sel_i     (res_sel_i),
      .conv_o        (conv_r),
      .setup_o       (setup_r),
      .avg_o         (avg_r),
      .rst_o         (rst_r),
      .dac_default_o (dac_default_o)
   );

   adc_cmd_start_eoc #(.SYNC_STAGES(SYNC_STAGES)) u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n_i),
      .cnvst_n_i   (cnvst_n_i),
      .conv_done_i (conv_done_i),
      .conv_cmd_i  (cmd_valid_i && (kind == KIND_CONV)),
      .clk_mode_i  (setup_r.clk_mode),
      .conv_req_o  (conv_req_o),
      .eoc_n_o     (eoc_n_o)
   );

   // One-cycle command pulses, one flop each
   cmd_kind_e pulse_kind [NPULSE];
   logic [NPULSE-1:0] pulse_q;

   assign pulse_kind[0] = KIND_GPIO_CFG;
   assign pulse_kind[1] = KIND_GPIO_WR;
   assign pulse_kind[2] = KIND_GPIO_RD;
   assign pulse_kind[3] = KIND_DAC_SEL;

   for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pulse_q[i] <= 1'b0;
         else
            pulse_q[i] <= cmd_valid_i && (kind == pulse_kind[i]);
      end
   end

   assign gpio_cfg_o = pulse_q[0];
   assign gpio_wr_o  = pulse_q[1];
   assign gpio_rd_o  = pulse_q[2];
   assign dac_sel_o  = pulse_q[3];

   wire ext_mode = (setup_r.clk_mode == MODE_EXT_CLK);

   assign chan_o       = conv_r.chan;
   assign scan_o       = conv_r.scan;
   assign temp_o       = conv_r.temp;
   assign clk_mode_o   = setup_r.clk_mode;
   assign ref_sel_o    = setup_r.ref_sel;
   assign diff_sel_o   = setup_r.diff_sel;
   assign avg_en_o     = avg_r.en;
   assign avg_cnt_o    = avg_r.cnt;
   assign scan_rep_o   = avg_r.rep;
   assign eff_scan_o   = ext_mode ? 2'b00 : conv_r.scan;
   assign eff_avg_en_o = ext_mode ? 1'b0 : avg_r.en;
   assign slow_o       = rst_r.slow;
   assign fbgon_o      = rst_r.fbgon;

endmodule

// File: rtl/adc_cmd_decoder_chk.sv
module adc_cmd_decoder_chk #(
   parameter int BYTE_W = 8,
   parameter int DAC_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] cmd_byte_i,
   input logic              cmd_valid_i,
   input logic              cs_n_i,
   input logic              cnvst_n_i,
   input logic              conv_done_i,
   input logic [3:0]        chan_o,
   input logic [1:0]        scan_o,
   input logic              temp_o,
   input logic [1:0]        clk_mode_o,
   input logic [1:0]        ref_sel_o,
   input logic [1:0]        diff_sel_o,
   input logic              avg_en_o,
   input logic [1:0]        avg_cnt_o,
   input logic [1:0]        scan_rep_o,
   input logic [1:0]        eff_scan_o,
   input logic              eff_avg_en_o,
   input logic              conv_req_o,
   input logic              gpio_cfg_o,
   input logic              gpio_wr_o,
   input logic              gpio_rd_o,
   input logic              dac_sel_o,
   input logic              eoc_n_o
);

   // R5: byte-derived pulses are mutually exclusive
   assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gpio_cfg_o, gpio_wr_o, gpio_rd_o, dac_sel_o}));

   // R4: a DAC-select command leaves every field untouched
   assert_dacsel_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sel_o |-> $stable({chan_o, scan_o, temp_o, clk_mode_o, ref_sel_o,
                             diff_sel_o, avg_en_o, avg_cnt_o, scan_rep_o}));

   // R8: bus start in modes 2 and 3
   assert_bus_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_byte_i[7] && clk_mode_o[1]) |=> conv_req_o);

   // R10: mode 3 forces effective scan and averaging off
   assert_ext_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_mode_o == 2'b11) |-> (eff_scan_o == 2'b00 && !eff_avg_en_o));

   // R11: chip-select falling edge raises the flag
   assert_cs_fall_eoc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_n_i) && !cs_n_i) |=> eoc_n_o);

   // R12: flag stays high in mode 3
   assert_ext_eoc_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_mode_o == 2'b11) |-> eoc_n_o);

endmodule

bind adc_cmd_decoder adc_cmd_decoder_chk #(.BYTE_W(BYTE_W), .DAC_W(DAC_W)) u_chk (.*);

// File: tb/adc_cmd_decoder_bench.sv
module adc_cmd_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int EV_CONV = 1, EV_GCFG = 2, EV_GWR = 3, EV_GRD = 4, EV_DAC = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] cmd_byte_i = '0;
   logic cmd_valid_i = 1'b0, cs_n_i = 1'b1, cnvst_n_i = 1'b1;
   logic conv_done_i = 1'b0, res_sel_i = 1'b1;
   logic [3:0] chan_o;
   logic [1:0] scan_o, clk_mode_o, ref_sel_o, diff_sel_o, avg_cnt_o, scan_rep_o, eff_scan_o;
   logic temp_o, avg_en_o, eff_avg_en_o, slow_o, fbgon_o;
   logic [11:0] dac_default_o;
   logic conv_req_o, gpio_cfg_o, gpio_wr_o, gpio_rd_o, dac_sel_o, eoc_n_o;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   int exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_cmd_decoder u_adc_cmd_decoder (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   // Monitor: every pulse event must match the scoreboard front
   task automatic see(input int ev);
      int e;
      if (exp_q.size() == 0) begin
         check(0, "R8/R9/R4/R5 unexpected pulse", ev, 0);
      end else begin
         e = exp_q.pop_front();
         check_eq("R8/R9/R4/R5 pulse order", ev, e);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (conv_req_o) see(EV_CONV);
         if (gpio_cfg_o) see(EV_GCFG);
         if (gpio_wr_o)  see(EV_GWR);
         if (gpio_rd_o)  see(EV_GRD);
         if (dac_sel_o)  see(EV_DAC);
      end
   end

   // Driver: one byte, one cycle; returns at the negedge the result is visible
   task automatic send(input logic [7:0] b, input int ev);
      @(negedge clk);
      cmd_byte_i  = b;
      cmd_valid_i = 1'b1;
      if (ev != 0) exp_q.push_back(ev);
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic drain(input string req);
      @(negedge clk);
      @(negedge clk);
      check_eq(req, exp_q.size(), 0);
   endtask

   function automatic int all_regs();
      return {chan_o, scan_o, temp_o, clk_mode_o, ref_sel_o, diff_sel_o,
              avg_en_o, avg_cnt_o, scan_rep_o, slow_o, fbgon_o};
   endfunction

   task automatic finish_run();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 power-up state
      check_eq("R6 setup", {clk_mode_o, ref_sel_o, diff_sel_o}, 6'h28);
      check_eq("R6 conv", {chan_o, scan_o, temp_o}, 0);
      check_eq("R6 avg/rst", {avg_en_o, avg_cnt_o, scan_rep_o, slow_o, fbgon_o}, 0);
      check_eq("R6 dac default high", dac_default_o, 12'hFFF);
      check_eq("R6 eoc", eoc_n_o, 1);

      // R1 + R8: conversion byte in mode 2
      send(8'hB5, EV_CONV);
      check_eq("R1 conv fields", {chan_o, scan_o, temp_o}, {4'h6, 2'b10, 1'b1});
      check_eq("R10 eff scan follows", eff_scan_o, 2'b10);
      drain("R8 bus start mode 2");

      // R2 setup, mode 1
      send(8'h5E, 0);
      check_eq("R2 setup fields", {clk_mode_o, ref_sel_o, diff_sel_o}, {2'b01, 2'b11, 2'b10});

      // R3 averaging
      send(8'h3B, 0);
      check_eq("R3 avg fields", {avg_en_o, avg_cnt_o, scan_rep_o}, {1'b1, 2'b10, 2'b11});
      check_eq("R10 eff avg follows", eff_avg_en_o, 1);

      // R4 DAC select ignores low nibble
      snap = all_regs();
      send(8'h1F, EV_DAC);
      check_eq("R4 regs unchanged", all_regs(), snap);
      drain("R4 dac pulse");

      // R5 GPIO and no-op / unused
      send(8'h03, EV_GCFG);
      send(8'h02, EV_GWR);
      send(8'h01, EV_GRD);
      send(8'h00, 0);
      send(8'h05, 0);
      send(8'h07, 0);
      check_eq("R5 regs unchanged", all_regs(), snap);
      drain("R5 gpio pulses");

      // R8: conversion byte in mode 1 loads but no request
      send(8'h80, 0);
      check_eq("R8 fields load mode 1", {chan_o, scan_o, temp_o}, 0);
      drain("R8 no bus start mode 1");

      // R11: done drives flag low
      @(negedge clk) conv_done_i = 1'b1;
      @(negedge clk) conv_done_i = 1'b0;
      check_eq("R11 eoc low after done", eoc_n_o, 0);

      // R9 + R11: strobe edge in mode 1
      @(negedge clk) begin cnvst_n_i = 1'b0; exp_q.push_back(EV_CONV); end
      @(negedge clk);
      check_eq("R11 eoc high after cnvst fall", eoc_n_o, 1);
      cnvst_n_i = 1'b1;
      drain("R9 cnvst request mode 1");

      // R11: simultaneous cs fall and done, edge wins
      @(negedge clk) conv_done_i = 1'b1;
      @(negedge clk) begin conv_done_i = 1'b1; cs_n_i = 1'b0; end
      check_eq("R11 low before race", eoc_n_o, 0);
      @(negedge clk) begin conv_done_i = 1'b0; end
      check_eq("R11 cs fall wins", eoc_n_o, 1);
      cs_n_i = 1'b1;

      // R10 + R12 mode 3
      send(8'h70, 0);
      check_eq("R12 eoc high mode 3", eoc_n_o, 1);
      send(8'h86, EV_CONV);
      check_eq("R10 stored scan", scan_o, 2'b11);
      check_eq("R10 eff overrides", {eff_scan_o, eff_avg_en_o}, 0);
      @(negedge clk) conv_done_i = 1'b1;
      @(negedge clk) conv_done_i = 1'b0;
      check_eq("R12 done ignored mode 3", eoc_n_o, 1);
      drain("R8 bus start mode 3");

      // R9: strobe edge ignored in mode 3
      @(negedge clk) cnvst_n_i = 1'b0;
      @(negedge clk) cnvst_n_i = 1'b1;
      drain("R9 no cnvst request mode 3");

      // R7: soft fields, then full restore with res_sel low
      snap = all_regs();
      send(8'h0B, 0);
      check_eq("R7 slow/fbgon", {slow_o, fbgon_o}, 2'b11);
      check_eq("R7 other regs kept", all_regs() >> 2, snap >> 2);
      res_sel_i = 1'b0;
      send(8'h0C, 0);
      check_eq("R7 setup restored", {clk_mode_o, ref_sel_o, diff_sel_o}, 6'h28);
      check_eq("R7 others cleared", {chan_o, scan_o, temp_o, avg_en_o, avg_cnt_o,
                                      scan_rep_o, slow_o, fbgon_o}, 0);
      check_eq("R7 dac default low", dac_default_o, 0);
      drain("R7 no stray pulses");

      finish_run();
   end

endmodule